// File: doc/BRIEF.md
# Core Low-Power State Sequencer

This block tracks the power state of a processor core that runs two hardware threads. It watches per-thread halt levels, a stop-clock request from the platform, break events (system-management interrupt, INIT, bus init and two local interrupt lines), a core initialize request and bus snoop activity. From these it works out which of five states the core is in: running, halted, halted at a reduced operating point, stop-granted, or servicing a snoop while stop-granted.

The stop-granted state is not entered as soon as stop-clock rises. The core first completes an acknowledge bus cycle, and the controller counts a fixed number of bus clocks after the response phase of that cycle before it switches state. Stop-clock nests over both halt states and returns the core to whichever one it left. A bus-init event that arrives while stop-granted is not serviced. Instead it is held in a pending flag that software clears. A separate voltage and frequency sequencer receives one-cycle entry and exit requests for the reduced operating point.

Top module: `pwr_state_ctrl`

## Requirements
- R1: State codes on `pstate` are 0 running, 1 halted, 2 enhanced halted, 3 stop-granted and 4 snoop in stop-grant. When running, with `stpclk_req`, `core_init_req` and every break input low, the state moves to 1 on the next clock if and only if every bit of `thr_halt` is set and `ehalt_en` is 0. If only some threads are halted, the state stays 0.
- R2: Under the same conditions with `ehalt_en` at 1, the state moves to 2 instead. In the same cycle `vf_enter_req` pulses high for one cycle.
- R3: In state 1 or 2, with `stpclk_req` and `core_init_req` low, any of `brk_smi`, `brk_init`, `brk_binit` or a bit of `brk_lint` returns the state to 0 on the next clock. Leaving the reduced operating point for state 0 pulses `vf_exit_req` for one cycle.
- R4: While `stpclk_req` is high in state 0, 1 or 2, no halt or break transition occurs. After stop-grant, dropping `stpclk_req` returns the state to the one that was left (0, 1 or 2).
- R5: The state becomes 3 exactly `SG_DELAY` (default 20) clock edges after the edge that samples `sga_resp` high while `stpclk_req` is high. If `stpclk_req` drops before then, the count is abandoned and a new `sga_resp` is needed.
- R6: `brk_binit` sampled in state 3 or 4 sets `binit_pend` on the next clock and leaves the state unchanged. The flag survives leaving stop-grant and clears only on `binit_clr`, or on `core_init_req` outside states 3 and 4. If set and clear fall in the same cycle, set wins.
- R7: `core_init_req` in state 3 or 4 keeps the state and pulses `core_init` on the next clock. A later drop of `stpclk_req` then returns the state to 0, whatever state was left.
- R8: `snoop_hit` in state 3 moves to state 4. `snoop_done` in state 4 returns to state 3. `snoop_svc` is high in state 4, and also whenever `snoop_hit` is high in states 0, 1 or 2, without any change of state.
- R9: `core_init_req` in state 0, 1 or 2 forces state 0 on the next clock, clears `binit_pend`, abandons any stop-grant count, and drives `core_init` high one cycle later.
- R10: Among events in the same cycle, `core_init_req` wins over `stpclk_req`, `stpclk_req` wins over break events, and a break event wins over halt entry from state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| thr_halt | input | NTHR | Per-thread halted level |
| ehalt_en | input | 1 | Use the reduced operating point when all threads halt |
| stpclk_req | input | 1 | Platform stop-clock request level |
| sga_resp | input | 1 | Response phase of the stop-grant acknowledge cycle |
| brk_smi | input | 1 | System-management interrupt break event |
| brk_init | input | 1 | INIT break event |
| brk_binit | input | 1 | Bus-init break event |
| brk_lint | input | NLINT | Local interrupt lines (NMI, INTR) |
| core_init_req | input | 1 | Core initialize request |
| snoop_hit | input | 1 | Bus snoop detected |
| snoop_done | input | 1 | Snoop service complete strobe |
| binit_clr | input | 1 | Software clear of the pending bus-init flag |
| pstate | output | 3 | Current power state code |
| snoop_svc | output | 1 | Snoop service enable |
| binit_pend | output | 1 | Bus-init latched during stop-grant |
| core_init | output | 1 | Internal initialize pulse |
| vf_enter_req | output | 1 | Request to move to the reduced operating point |
| vf_exit_req | output | 1 | Request to return to the full operating point |

## Verification
Two kinds of event often coincide. The first is a stop-clock request or stop-grant count that expires in the same cycle as a break event or a full-halt indication. The second is a core initialize request that meets a bus-init event or a software clear while the core is stop-granted. Random stimulus holds stop-clock and the halt levels for many cycles and fires break, snoop, reset and clear strobes at low rates, so these events land together on their own. Directed cases force the exact coincidences. Each cycle, a cycle-level model that applies the stated priority judges the outcome.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_HALT  = 3'd1,
    PS_EHALT = 3'd2,
    PS_STOP  = 3'd3,
    PS_SNOOP = 3'd4
  } pstate_e;

  function automatic logic is_active(input pstate_e s);
    return (s == PS_RUN) || (s == PS_HALT) || (s == PS_EHALT);
  endfunction

endpackage

// File: rtl/pwr_evt_decode.sv
module pwr_evt_decode #(
  parameter int NTHR  = 2,
  parameter int NLINT = 2
) (
  input  logic [NTHR-1:0]  thr_halt,
  input  logic             brk_smi,
  input  logic             brk_init,
  input  logic             brk_binit,
  input  logic [NLINT-1:0] brk_lint,
  output logic             all_halted,
  output logic             brk_any
);

  logic [NTHR:0]  halt_chain;
  logic [NLINT:0] lint_chain;

  assign halt_chain[0] = 1'b1;
  assign lint_chain[0] = 1'b0;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign halt_chain[t+1] = halt_chain[t] & thr_halt[t];
  end

  for (genvar l = 0; l < NLINT; l++) begin : g_lint
    assign lint_chain[l+1] = lint_chain[l] | brk_lint[l];
  end

  assign all_halted = halt_chain[NTHR];
  assign brk_any    = brk_smi | brk_init | brk_binit | lint_chain[NLINT];

endmodule

// File: rtl/pwr_sg_timer.sv
module pwr_sg_timer #(
  parameter int SG_DELAY = 20,
  localparam int CW = (SG_DELAY > 1) ? $clog2(SG_DELAY) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_ok,
  input  logic sga_resp,
  output logic expire
);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (!arm_ok) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      if (cnt_q == '0) begin
        armed_d = 1'b0;
      end else begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end else if (sga_resp) begin
      armed_d = 1'b1;
      cnt_en  = 1'b1;
      cnt_d   = CW'(SG_DELAY - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign expire = arm_ok && armed_q && (cnt_q == '0);

  // R5
  arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_ok && !armed_q && sga_resp) |=> armed_q || !arm_ok);

  // R5
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_ok |=> !armed_q);

endmodule

// File: rtl/pwr_binit_latch.sv
module pwr_binit_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic init_clr,
  input  logic sw_clr,
  output logic pend
);

  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (init_clr)     pend_d = 1'b0;
    else if (set_evt) pend_d = 1'b1;
    else if (sw_clr)  pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !init_clr) |=> pend);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !init_clr && !sw_clr) |=> pend);

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int NTHR     = 2,
  parameter int NLINT    = 2,
  parameter int SG_DELAY = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTHR-1:0]  thr_halt,
  input  logic             ehalt_en,
  input  logic             stpclk_req,
  input  logic             sga_resp,
  input  logic             brk_smi,
  input  logic             brk_init,
  input  logic             brk_binit,
  input  logic [NLINT-1:0] brk_lint,
  input  logic             core_init_req,
  input  logic             snoop_hit,
  input  logic             snoop_done,
  input  logic             binit_clr,
  output logic [2:0]       pstate,
  output logic             snoop_svc,
  output logic             binit_pend,
  output logic             core_init,
  output logic             vf_enter_req,
  output logic             vf_exit_req
);

  pstate_e st_q, st_d;
  pstate_e base_q, base_d;
  logic    vf_low_q, vf_low_d;
  logic    vf_en_q, vf_ex_q, init_q;
  logic    all_halted, brk_any;
  logic    in_stop, arm_ok, sg_expire;

  assign in_stop = (st_q == PS_STOP) || (st_q == PS_SNOOP);
  assign arm_ok  = stpclk_req && !core_init_req && is_active(st_q);

  pwr_evt_decode #(.NTHR(NTHR), .NLINT(NLINT)) u_evt (
    .thr_halt   (thr_halt),
    .brk_smi    (brk_smi),
    .brk_init   (brk_init),
    .brk_binit  (brk_binit),
    .brk_lint   (brk_lint),
    .all_halted (all_halted),
    .brk_any    (brk_any)
  );

  pwr_sg_timer #(.SG_DELAY(SG_DELAY)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_ok   (arm_ok),
    .sga_resp (sga_resp),
    .expire   (sg_expire)
  );

  pwr_binit_latch u_binit (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (brk_binit && in_stop),
    .init_clr (core_init_req && !in_stop),
    .sw_clr   (binit_clr),
    .pend     (binit_pend)
  );

  // next-state logic: reset, then stop-clock, then break, then halt entry
  always_comb begin
    st_d   = st_q;
    base_d = base_q;
    if (core_init_req) begin
      if (in_stop) base_d = PS_RUN;
      else         st_d   = PS_RUN;
    end else begin
      unique case (st_q)
        PS_STOP: begin
          if (snoop_hit)        st_d = PS_SNOOP;
          else if (!stpclk_req) st_d = base_q;
        end
        PS_SNOOP: begin
          if (snoop_done) st_d = PS_STOP;
        end
        PS_RUN: begin
          if (stpclk_req) begin
            if (sg_expire) begin
              st_d   = PS_STOP;
              base_d = PS_RUN;
            end
          end else if (all_halted && !brk_any) begin
            st_d = ehalt_en ? PS_EHALT : PS_HALT;
          end
        end
        PS_HALT, PS_EHALT: begin
          if (stpclk_req) begin
            if (sg_expire) begin
              st_d   = PS_STOP;
              base_d = st_q;
            end
          end else if (brk_any) begin
            st_d = PS_RUN;
          end
        end
        default: st_d = PS_RUN;
      endcase
    end
  end

  always_comb begin
    vf_low_d = vf_low_q;
    if (st_d == PS_EHALT)    vf_low_d = 1'b1;
    else if (st_d == PS_RUN) vf_low_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= PS_RUN;
      base_q   <= PS_RUN;
      vf_low_q <= 1'b0;
      vf_en_q  <= 1'b0;
      vf_ex_q  <= 1'b0;
      init_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      base_q   <= base_d;
      vf_low_q <= vf_low_d;
      vf_en_q  <= (st_d == PS_EHALT) && !vf_low_q;
      vf_ex_q  <= (st_d == PS_RUN) && vf_low_q;
      init_q   <= core_init_req;
    end
  end

  assign pstate       = st_q;
  assign core_init    = init_q;
  assign vf_enter_req = vf_en_q;
  assign vf_exit_req  = vf_ex_q;
  assign snoop_svc    = (st_q == PS_SNOOP) || (snoop_hit && is_active(st_q));

  // R1
  partial_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && !all_halted && !stpclk_req && !core_init_req)
    |=> pstate == 3'd0);

  // R4
  stop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_STOP && !stpclk_req && !snoop_hit && !core_init_req)
    |=> pstate != 3'd3);

  // R7
  init_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_STOP && core_init_req && stpclk_req && !snoop_hit)
    |=> (pstate == 3'd3) && core_init);

  // R9
  init_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_active(st_q) && core_init_req) |=> (pstate == 3'd0) && !binit_pend);

  // R2
  vf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vf_enter_req |=> !vf_enter_req);

endmodule

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;

  localparam int NTHR = 2;
  localparam int NLINT = 2;
  localparam int SGD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NTHR-1:0] thr_halt = '0;
  logic ehalt_en = 1'b0, stpclk_req = 1'b0, sga_resp = 1'b0;
  logic brk_smi = 1'b0, brk_init = 1'b0, brk_binit = 1'b0;
  logic [NLINT-1:0] brk_lint = '0;
  logic core_init_req = 1'b0, snoop_hit = 1'b0, snoop_done = 1'b0, binit_clr = 1'b0;
  logic [2:0] pstate;
  logic snoop_svc, binit_pend, core_init, vf_enter_req, vf_exit_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_state_ctrl #(.NTHR(NTHR), .NLINT(NLINT), .SG_DELAY(SGD)) dut_i (
    .clk(clk), .rst_n(rst_n), .thr_halt(thr_halt), .ehalt_en(ehalt_en),
    .stpclk_req(stpclk_req), .sga_resp(sga_resp), .brk_smi(brk_smi),
    .brk_init(brk_init), .brk_binit(brk_binit), .brk_lint(brk_lint),
    .core_init_req(core_init_req), .snoop_hit(snoop_hit), .snoop_done(snoop_done),
    .binit_clr(binit_clr), .pstate(pstate), .snoop_svc(snoop_svc),
    .binit_pend(binit_pend), .core_init(core_init), .vf_enter_req(vf_enter_req),
    .vf_exit_req(vf_exit_req)
  );

  // cycle-level expectation built from the requirements
  logic [2:0] m_st, m_base;
  logic m_armed, m_pend, m_init, m_low, m_ven, m_vex;
  int m_cnt;

  function automatic bit active(input logic [2:0] s);
    return s <= 3'd2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [2:0] nst, nbase;
    logic brk, stop;
    if (!rst_n) begin
      m_st = 0; m_base = 0; m_armed = 0; m_cnt = 0; m_pend = 0;
      m_init = 0; m_low = 0; m_ven = 0; m_vex = 0;
    end else begin
      brk  = brk_smi | brk_init | brk_binit | (|brk_lint);
      stop = (m_st == 3'd3) || (m_st == 3'd4);
      nst = m_st; nbase = m_base;
      if (core_init_req) begin
        if (stop) nbase = 0; else nst = 0;
        m_armed = 0;
      end else if (m_st == 3'd3) begin
        if (snoop_hit) nst = 4; else if (!stpclk_req) nst = m_base;
      end else if (m_st == 3'd4) begin
        if (snoop_done) nst = 3;
      end else if (stpclk_req) begin
        if (m_armed) begin
          if (m_cnt == 0) begin nst = 3; nbase = m_st; m_armed = 0; end
          else m_cnt = m_cnt - 1;
        end else if (sga_resp) begin
          m_armed = 1; m_cnt = SGD - 1;
        end
      end else begin
        m_armed = 0;
        if (m_st == 0) begin
          if ((&thr_halt) && !brk) nst = ehalt_en ? 3'd2 : 3'd1;
        end else if (brk) nst = 0;
      end
      if (core_init_req && !stop) m_pend = 0;
      else if (brk_binit && stop) m_pend = 1;
      else if (binit_clr) m_pend = 0;
      m_ven  = (nst == 2) && !m_low;
      m_vex  = (nst == 0) && m_low;
      if (nst == 2) m_low = 1; else if (nst == 0) m_low = 0;
      m_init = core_init_req;
      m_st = nst; m_base = nbase;
    end
  end

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk(string tag);
    logic exp_svc;
    exp_svc = (m_st == 3'd4) || (snoop_hit && active(m_st));
    cmp(tag, "pstate", pstate, m_st);
    if (pstate != m_st) begin end
    if (binit_pend != m_pend) cmp(tag, "binit_pend", binit_pend, m_pend);
    if (core_init != m_init) cmp(tag, "core_init", core_init, m_init);
    if (vf_enter_req != m_ven) cmp(tag, "vf_enter_req", vf_enter_req, m_ven);
    if (vf_exit_req != m_vex) cmp(tag, "vf_exit_req", vf_exit_req, m_vex);
    if (snoop_svc != exp_svc) cmp(tag, "snoop_svc", snoop_svc, exp_svc);
  endtask

  task automatic quiet();
    thr_halt = '0; ehalt_en = 0; stpclk_req = 0; sga_resp = 0; brk_smi = 0;
    brk_init = 0; brk_binit = 0; brk_lint = '0; core_init_req = 0;
    snoop_hit = 0; snoop_done = 0; binit_clr = 0;
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic to_stop(int ehl);
    stpclk_req = 1; sga_resp = 1; step(); sga_resp = 0;
    step(SGD);
    cmp("R5", "pstate at stop-grant", pstate, 3);
  endtask

  initial begin
    void'($urandom(32'd4242));
    step(2);
    cmp("R9", "reset pstate", pstate, 0);
    cmp("R9", "reset binit_pend", binit_pend, 0);
    rst_n = 1; step();

    // R1 partial then full halt
    thr_halt = 2'b01; step(2); cmp("R1", "one thread halted", pstate, 0);
    thr_halt = 2'b11; step(); cmp("R1", "all halted", pstate, 1); chk("R1");
    // R8 snoop served in halt without leaving
    snoop_hit = 1; #1; cmp("R8", "snoop_svc in halt", snoop_svc, 1);
    step(); snoop_hit = 0; cmp("R8", "halt kept on snoop", pstate, 1);
    // R3 break exit
    brk_lint = 2'b10; step(); brk_lint = 0; thr_halt = 0;
    cmp("R3", "lint exit", pstate, 0); chk("R3");

    // R2 enhanced halt with vf pulse
    ehalt_en = 1; thr_halt = 2'b11; step();
    cmp("R2", "enhanced state", pstate, 2); cmp("R2", "vf_enter", vf_enter_req, 1);
    step(); cmp("R2", "vf_enter one cycle", vf_enter_req, 0);

    // R5 exact delay and R4 return to enhanced halt
    stpclk_req = 1; brk_smi = 1; sga_resp = 1; step(); sga_resp = 0;
    step(SGD - 1); cmp("R10", "break masked by stop-clock", pstate, 2);
    brk_smi = 0;
    cmp("R5", "one edge before expiry", pstate, 2);
    step(); cmp("R5", "expiry edge", pstate, 3); chk("R5");
    // R6 binit latched, R8 snoop
    brk_binit = 1; binit_clr = 1; step(); brk_binit = 0; binit_clr = 0;
    cmp("R6", "pend set wins over clear", binit_pend, 1); cmp("R6", "still stop", pstate, 3);
    snoop_hit = 1; step(); snoop_hit = 0;
    cmp("R8", "snoop state", pstate, 4); cmp("R8", "svc in snoop", snoop_svc, 1);
    snoop_done = 1; step(); snoop_done = 0; cmp("R8", "back to stop", pstate, 3);
    stpclk_req = 0; step(); cmp("R4", "return to enhanced", pstate, 2);
    cmp("R6", "pend survives exit", binit_pend, 1); chk("R4");
    binit_clr = 1; step(); binit_clr = 0; cmp("R6", "sw clear", binit_pend, 0);

    // R7 reset inside stop-grant
    to_stop(1);
    core_init_req = 1; step(); core_init_req = 0;
    cmp("R7", "state kept", pstate, 3); cmp("R7", "init pulse", core_init, 1);
    thr_halt = 0; stpclk_req = 0; step(); cmp("R7", "drop to running", pstate, 0);
    cmp("R3", "vf_exit after low point", vf_exit_req, 1); chk("R7");

    // R5 cancel
    stpclk_req = 1; sga_resp = 1; step(); sga_resp = 0; step(5);
    stpclk_req = 0; step(); stpclk_req = 1; step(SGD + 3);
    cmp("R5", "cancelled count", pstate, 0);
    // R9 reset clears count, R10 reset beats stop-clock
    sga_resp = 1; step(); sga_resp = 0; step(SGD - 2);
    core_init_req = 1; step(); core_init_req = 0; step(3);
    cmp("R10", "reset beats count", pstate, 0); chk("R9");
    stpclk_req = 0;
    // R10 break beats halt entry
    ehalt_en = 0; thr_halt = 2'b11; brk_init = 1; step(); brk_init = 0;
    cmp("R10", "break beats halt", pstate, 0); thr_halt = 0; step();

    // random phase
    quiet(); step();
    for (int c = 0; c < 6000; c++) begin
      chk("R10 random");
      if ($urandom % 16 == 0) thr_halt = 2'($urandom);
      if ($urandom % 40 == 0) stpclk_req = ~stpclk_req;
      if ($urandom % 64 == 0) ehalt_en = ~ehalt_en;
      sga_resp      = ($urandom % 8 == 0);
      brk_smi       = ($urandom % 50 == 0);
      brk_init      = ($urandom % 50 == 0);
      brk_binit     = ($urandom % 30 == 0);
      brk_lint      = ($urandom % 25 == 0) ? 2'($urandom) : 2'b00;
      core_init_req = ($urandom % 90 == 0);
      snoop_hit     = ($urandom % 12 == 0);
      snoop_done    = ($urandom % 5 == 0);
      binit_clr     = ($urandom % 40 == 0);
      step();
    end
    chk("R6 final");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule